// File: doc/BRIEF.md
# Program/Erase Status Bit Generator

This block sits between a flash array and the host read port. While the bank is idle it forwards the array word to the host. While an internal program or erase runs, or while an erase is suspended, it can instead return a status word. Bit 7 of that word tells the host the polarity of the pending operation. Bit 6 flips on every read while the bank is busy. Bit 2 flips on every read that concerns an erasing or erase-suspended region. Software polls these bits to learn when a write has finished and whether a given address lies in a suspended region.

Every accepted read strobe registers one output word. The two toggle flip-flops advance only on accepted strobes, so the status sequence depends on how many reads the host has made and not on how much time has passed. The suspended region is given as a base address and a mask. An address is inside the region when it matches the base on every bit the mask selects.

Top module: `ew_status_gen`

## Requirements
- R1: After reset, rd_data is 0 and both toggle flip-flops are 0, so the first status read returns bit 6 = 0 and bit 2 = 0.
- R2: rd_data takes a new value on the clock edge that samples rd_stb high, and holds its value on every edge where rd_stb is low.
- R3: When busy and susp are both low, a read returns arr_data unchanged.
- R4: While busy is high and op_erase is 0 (program), bit 7 of a read is the complement of prog_word bit 7.
- R5: While busy is high and op_erase is 1 (erase), bit 7 of a read is 0.
- R6: Bit 6 of reads taken while busy is high alternates from one such read to the next. Clocks without a strobe, and reads taken while not busy, leave its state unchanged.
- R7: Bit 2 alternates over successive reads taken during an erase or inside a suspended region. A read during a program returns the current bit 2 state and does not advance it.
- R8: While busy is low and susp is high, a read whose address satisfies ((rd_addr ^ susp_base) & susp_mask) == 0 returns bit 7 = 1 and bit 6 = 1.
- R9: While busy is low and susp is high, a read outside the suspended region returns arr_data unchanged.
- R10: A program started while susp is high (busy = 1, op_erase = 0) returns program status for every address, with bit 6 alternating.
- R11: In every status word, all bits other than 7, 6 and 2 read 0.
- R12: Once busy falls after an erase, reads return array data again (an erased word reads 16'hFFFF, so bit 7 = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Accepted read strobe, one per read |
| rd_addr | input | AW | Read word address |
| arr_data | input | 16 | Word from the array at rd_addr |
| op_erase | input | 1 | Type of running operation: 1 erase, 0 program |
| prog_word | input | 16 | Latched data of the word being programmed |
| busy | input | 1 | Internal program or erase in progress |
| susp | input | 1 | An erase is suspended |
| susp_base | input | AW | Base address of the suspended region |
| susp_mask | input | AW | Address bits that define the suspended region |
| rd_data | output | 16 | Registered read word |

## Verification
Every result is due one clock edge after the strobe that asks for it. The bench drives inputs on the falling edge, raises rd_stb for one cycle and compares rd_data on the next falling edge, after exactly one rising edge has passed. Between reads it inserts idle cycles with busy held high and confirms that the output holds. The next status read then proves that the idle clocks did not advance the toggle state. The bench keeps its own copy of the two toggle states and advances it only on the reads that the requirements name.

// File: rtl/ew_status_gen.sv
module ew_status_gen #(
  parameter int AW       = 21,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6,
  parameter int ALT_BIT  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic [15:0]   arr_data,
  input  logic          op_erase,
  input  logic [15:0]   prog_word,
  input  logic          busy,
  input  logic          susp,
  input  logic [AW-1:0] susp_base,
  input  logic [AW-1:0] susp_mask,
  output logic [15:0]   rd_data
);

  logic tog_a, tog_b;
  logic [15:0] stat, nxt;

  wire in_reg     = ((rd_addr ^ susp_base) & susp_mask) == '0;
  wire prog_busy  = busy & ~op_erase;
  wire erase_busy = busy & op_erase;
  wire susp_hit   = ~busy & susp & in_reg;

  always_comb begin
    stat = '0;
    stat[ALT_BIT] = tog_b;
    if (prog_busy) begin
      stat[POLL_BIT] = ~prog_word[POLL_BIT];
      stat[TOG_BIT]  = tog_a;
    end else if (erase_busy) begin
      stat[POLL_BIT] = 1'b0;
      stat[TOG_BIT]  = tog_a;
    end else begin
      stat[POLL_BIT] = 1'b1;
      stat[TOG_BIT]  = 1'b1;
    end
  end

  assign nxt = (busy | susp_hit) ? stat : arr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      tog_a   <= 1'b0;
      tog_b   <= 1'b0;
    end else if (rd_stb) begin
      rd_data <= nxt;
      if (busy) tog_a <= ~tog_a;
      if (erase_busy | susp_hit) tog_b <= ~tog_b;
    end
  end

endmodule

// File: rtl/ew_status_gen_chk.sv
module ew_status_gen_chk #(
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_stb,
  input logic [AW-1:0] rd_addr,
  input logic [15:0]   arr_data,
  input logic          op_erase,
  input logic [15:0]   prog_word,
  input logic          busy,
  input logic          susp,
  input logic [AW-1:0] susp_base,
  input logic [AW-1:0] susp_mask,
  input logic [15:0]   rd_data
);

  logic pend, have, prev6;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; have <= 1'b0; prev6 <= 1'b0;
    end else begin
      pend <= rd_stb & busy;
      if (pend) begin
        have  <= 1'b1;
        prev6 <= rd_data[6];
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !busy && !susp |=> rd_data == $past(arr_data));

  p_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && busy && !op_erase |=> rd_data[7] == !$past(prog_word[7]));

  p_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && busy && op_erase |=> !rd_data[7]);

  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend && have |-> rd_data[6] != prev6);

  p_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !busy && susp && (((rd_addr ^ susp_base) & susp_mask) == '0)
    |=> rd_data[7] && rd_data[6]);

  p_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && busy |=> (rd_data & 16'hFF3B) == 16'h0000);

endmodule

bind ew_status_gen ew_status_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
  .arr_data(arr_data), .op_erase(op_erase), .prog_word(prog_word),
  .busy(busy), .susp(susp), .susp_base(susp_base), .susp_mask(susp_mask),
  .rd_data(rd_data)
);

// File: tb/ew_status_gen_tb_top.sv
module ew_status_gen_tb_top;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_stb = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   arr_data = '0;
  logic          op_erase = 1'b0;
  logic [15:0]   prog_word = '0;
  logic          busy = 1'b0;
  logic          susp = 1'b0;
  logic [AW-1:0] susp_base = '0;
  logic [AW-1:0] susp_mask = '0;
  logic [15:0]   rd_data;

  int n_chk = 0, n_bad = 0;
  logic m6 = 1'b0, m2 = 1'b0;

  always #10 clk = ~clk;

  ew_status_gen #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .arr_data(arr_data), .op_erase(op_erase), .prog_word(prog_word),
    .busy(busy), .susp(susp), .susp_base(susp_base), .susp_mask(susp_mask),
    .rd_data(rd_data)
  );

  function automatic logic in_region(input logic [AW-1:0] a);
    return ((a ^ susp_base) & susp_mask) == '0;
  endfunction

  function automatic logic [15:0] expect_word();
    logic [15:0] w;
    w = '0;
    if (busy) begin
      w[7] = op_erase ? 1'b0 : ~prog_word[7];
      w[6] = m6;
      w[2] = m2;
    end else if (susp && in_region(rd_addr)) begin
      w[7] = 1'b1; w[6] = 1'b1; w[2] = m2;
    end else begin
      w = arr_data;
    end
    return w;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input string req);
    logic [15:0] e;
    e = expect_word();
    if (busy) m6 = ~m6;
    if ((busy && op_erase) || (!busy && susp && in_region(rd_addr))) m2 = ~m2;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check(req, rd_data, e);
  endtask

  task automatic idle(input int n, input string req);
    logic [15:0] held;
    held = rd_data;
    for (int i = 0; i < n; i++) begin
      arr_data = 16'($urandom);
      @(negedge clk);
    end
    check(req, rd_data, held);
  endtask

  initial begin
    process::self().srandom(32'd1357);
    repeat (3) @(negedge clk);
    check("R1 reset", rd_data, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 idle pass-through
    rd_addr = 21'h00123; arr_data = 16'hA5C3; do_read("R3 pass");
    idle(4, "R2 hold");

    // R4 program, R1 first bit 6 is 0, R7 bit 2 frozen, R11
    busy = 1'b1; op_erase = 1'b0; prog_word = 16'h0080;
    arr_data = 16'h1234; do_read("R4 R1 R11 program poll");
    prog_word = 16'h0000; do_read("R4 R6 program poll");
    idle(5, "R2 R6 idle clocks while busy");
    do_read("R6 R7 no advance on idle");

    // R5 erase, bit 2 toggles
    op_erase = 1'b1;
    do_read("R5 R7 erase"); do_read("R5 R7 erase"); do_read("R5 R6 R7 erase");

    // R12 erase complete
    busy = 1'b0; arr_data = 16'hFFFF; do_read("R12 erased reads array");

    // R8 / R9 suspend
    susp = 1'b1; susp_mask = {AW{1'b1}} << 11; susp_base = 21'h05800;
    rd_addr = 21'h05A3F; arr_data = 16'h4321; do_read("R8 R7 suspended region");
    do_read("R8 R7 suspended region");
    rd_addr = 21'h06000; arr_data = 16'h5A5A; do_read("R9 outside region");
    do_read("R9 R6 outside region no toggle");

    // R10 program during suspend
    busy = 1'b1; op_erase = 1'b0; prog_word = 16'h00FF;
    rd_addr = 21'h06010; do_read("R10 program in suspend");
    rd_addr = 21'h05801; do_read("R10 program in suspend in-region addr");
    busy = 1'b0;
    do_read("R8 after program in suspend");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] mode;
      mode = 3'($urandom_range(0, 4));
      busy = (mode == 1 || mode == 2);
      op_erase = (mode == 2);
      susp = (mode == 3 || mode == 4) || (mode == 1 && $urandom_range(0, 1) == 1);
      susp_mask = {AW{1'b1}} << (($urandom_range(0, 1) == 1) ? 11 : 15);
      susp_base = AW'($urandom);
      rd_addr = ($urandom_range(0, 1) == 1) ? (susp_base ^ AW'($urandom_range(0, 2047))) : AW'($urandom);
      arr_data = 16'($urandom);
      prog_word = 16'($urandom);
      if (mode == 0) susp = 1'b0;
      do_read(busy ? (op_erase ? "R5 R6 R7 R11 random erase" : "R4 R6 R10 random program")
                   : (susp ? "R8 R9 random suspend" : "R3 random idle"));
      if ($urandom_range(0, 7) == 0) idle(int'($urandom_range(1, 4)), "R2 random hold");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule